// File: doc/BRIEF.md
# Dual-Mode Auto-Reload Timer

This block is a 16-bit up-counter whose low and high bytes software writes one at a time. A mode bit divides it into two independent 8-bit counters. In either mode a counter that passes its all-ones value reloads from its own byte of a 16-bit reload register instead of continuing from zero. Counting advances on a tick. The tick comes from one of three sources: every system clock cycle, one cycle in every twelve, or one cycle for every eighth rising edge of an asynchronous external oscillator. The external oscillator passes through a synchronizer chain before any edge is detected.

Each rollover sets a sticky flag, and a write clears it. An interrupt request combines the flags with two enable bits. A one-cycle pulse marks every high-side overflow so that neighbouring logic can use it as a trigger. The ctrl byte drives a small state machine with three states: ST_HALT (run bit clear), ST_WIDE (run set, split clear) and ST_SPLIT (run and split set). On every clock the register decodes the run and split bits captured on the previous edge. The transitions are therefore halt-to-wide, halt-to-split, wide-to-split, split-to-wide, and wide-or-split back to halt. Each transition takes effect one clock after the write that requests it.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset the count, reload value and ctrl byte are zero, both flags are clear, and irq and ovf_pulse are low.
- R2: A write with wr_addr 1 replaces only count bits [7:0], and wr_addr 2 replaces only bits [15:8]. Both are visible on count_o one cycle later. A count write takes precedence over any count step in the same cycle. wr_addr 3 and 4 write the low and high reload bytes.
- R3: While the state is ST_HALT (ctrl bit 0 clear), count_o holds its value.
- R4: In ST_WIDE (ctrl bit 1 clear), each tick adds one to the 16-bit count. A tick at 0xFFFF loads the 16-bit reload value.
- R5: Every high-side overflow sets flag_hi and drives ovf_pulse high for exactly the cycle in which the reloaded value first appears.
- R6: In ST_WIDE, a low-byte rollover from 0xFF sets flag_lo only when the low-rollover enable (ctrl bit 3) is set.
- R7: In ST_SPLIT, each byte adds one per tick and reloads from its own reload byte after 0xFF. The low byte sets flag_lo and the high byte sets flag_hi and ovf_pulse.
- R8: Flags stay set until a write to wr_addr 5, which loads flag_lo from wr_data[0] and flag_hi from wr_data[1]. A hardware set in the same cycle wins.
- R9: irq is high when the interrupt enable (ctrl bit 2) is set and either flag_hi is set, or flag_lo and the low-rollover enable are both set.
- R10: Ctrl bits [5:4] pick the tick source: 0 gives a tick every cycle, 1 gives a tick every 12 cycles, 2 gives a tick on every 8th synchronized rising edge of ext_osc, and 3 behaves as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 ctrl, 1 count low, 2 count high, 3 reload low, 4 reload high, 5 flags |
| wr_data | input | 8 | Write data |
| ext_osc | input | 1 | Asynchronous external oscillator |
| count_o | output | 16 | Current count value |
| flag_hi | output | 1 | High-side overflow flag |
| flag_lo | output | 1 | Low-byte rollover flag |
| irq | output | 1 | Interrupt request |
| ovf_pulse | output | 1 | One-cycle high-side overflow pulse |

## Verification
A wrong state in the mode machine or the counter shows on count_o within one tick. A value skipped or repeated, a reload that fails to happen, or a byte reloading from the wrong half breaks the sequence the scoreboard predicts at the very next count change. A fault in the prescaler or the synchronizer shows as a gap between count changes other than 12 or 80 cycles. A fault in the flag or enable logic shows on flag_lo, flag_hi or irq as soon as the run has been halted.

// File: rtl/drt_pkg.sv
package drt_pkg;
    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_WIDE  = 2'd1,
        ST_SPLIT = 2'd2
    } tmr_state_e;

    typedef enum logic [1:0] {
        SRC_SYS = 2'd0,
        SRC_DIV = 2'd1,
        SRC_EXT = 2'd2,
        SRC_ALT = 2'd3
    } tick_src_e;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADR_W  = 3;

    localparam logic [ADR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADR_W-1:0] A_CNT_L = 3'd1;
    localparam logic [ADR_W-1:0] A_CNT_H = 3'd2;
    localparam logic [ADR_W-1:0] A_RLD_L = 3'd3;
    localparam logic [ADR_W-1:0] A_RLD_H = 3'd4;
    localparam logic [ADR_W-1:0] A_FLAGS = 3'd5;
endpackage

// File: rtl/drt_tick_gen.sv
module drt_tick_gen
    import drt_pkg::*;
#(
    parameter int SYS_DIV     = 12,
    parameter int EXT_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  tick_src_e src,
    input  logic      ext_osc,
    output logic      tick
);
    localparam int PW = (SYS_DIV > 1) ? $clog2(SYS_DIV) : 1;
    localparam int EW = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1;

    logic [PW-1:0]          presc_q;
    logic [EW-1:0]          ext_cnt_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   presc_hit;
    logic                   ext_rise;

    assign presc_hit = (presc_q == PW'(SYS_DIV - 1));
    assign ext_rise  = sync_q[SYNC_STAGES-1] & ~last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
        end else if (presc_hit) begin
            presc_q <= '0;
        end else begin
            presc_q <= presc_q + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q    <= '0;
            last_q    <= 1'b0;
            ext_cnt_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ext_osc};
            last_q <= sync_q[SYNC_STAGES-1];
            if (ext_rise) begin
                if (ext_cnt_q == EW'(EXT_DIV - 1)) begin
                    ext_cnt_q <= '0;
                end else begin
                    ext_cnt_q <= ext_cnt_q + EW'(1);
                end
            end
        end
    end

    always_comb begin
        unique case (src)
            SRC_DIV: tick = presc_hit;
            SRC_EXT: tick = ext_rise && (ext_cnt_q == EW'(EXT_DIV - 1));
            default: tick = 1'b1;
        endcase
    end
endmodule

// File: rtl/drt_count_core.sv
module drt_count_core
    import drt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_state_e        state,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  rld,
    input  logic              lo_en,
    output logic [CNT_W-1:0]  cnt,
    output logic              set_lo,
    output logic              set_hi,
    output logic              ovf_pulse
);
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             step, lo_top, hi_top, ovf_q;

    assign lo_top = (cnt_q[BYTE_W-1:0] == '1);
    assign hi_top = (cnt_q[CNT_W-1:BYTE_W] == '1);
    assign step   = tick && (state != ST_HALT) && !(wr_lo || wr_hi);

    always_comb begin
        cnt_d  = cnt_q;
        set_lo = 1'b0;
        set_hi = 1'b0;
        unique case (state)
            ST_WIDE: begin
                if (step) begin
                    if (lo_top && hi_top) begin
                        cnt_d  = rld;
                        set_hi = 1'b1;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                    set_lo = lo_top & lo_en;
                end
            end
            ST_SPLIT: begin
                if (step) begin
                    cnt_d[BYTE_W-1:0] = lo_top ? rld[BYTE_W-1:0]
                                               : cnt_q[BYTE_W-1:0] + BYTE_W'(1);
                    cnt_d[CNT_W-1:BYTE_W] = hi_top ? rld[CNT_W-1:BYTE_W]
                                                   : cnt_q[CNT_W-1:BYTE_W] + BYTE_W'(1);
                    set_lo = lo_top;
                    set_hi = hi_top;
                end
            end
            default: ;
        endcase
        if (wr_lo) cnt_d[BYTE_W-1:0]     = wr_data;
        if (wr_hi) cnt_d[CNT_W-1:BYTE_W] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            ovf_q <= set_hi;
        end
    end

    assign cnt       = cnt_q;
    assign ovf_pulse = ovf_q;
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
    import drt_pkg::*;
#(
    parameter int SYS_DIV     = 12,
    parameter int EXT_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        ext_osc,
    output logic [15:0] count_o,
    output logic        flag_hi,
    output logic        flag_lo,
    output logic        irq,
    output logic        ovf_pulse
);
    tmr_state_e       state_q, state_d;
    tick_src_e        src_q;
    logic             run_q, split_q, irq_en_q, lo_en_q;
    logic [CNT_W-1:0] rld_q;
    logic             tick_w, set_lo_w, set_hi_w;
    logic             fl_hi_q, fl_lo_q;
    logic             wr_ctrl, wr_flags;

    assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
    assign wr_flags = wr_en && (wr_addr == A_FLAGS);

    // Control and reload registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            split_q  <= 1'b0;
            irq_en_q <= 1'b0;
            lo_en_q  <= 1'b0;
            src_q    <= SRC_SYS;
            rld_q    <= '0;
        end else if (wr_en) begin
            if (wr_ctrl) begin
                run_q    <= wr_data[0];
                split_q  <= wr_data[1];
                irq_en_q <= wr_data[2];
                lo_en_q  <= wr_data[3];
                src_q    <= tick_src_e'(wr_data[5:4]);
            end
            if (wr_addr == A_RLD_L) rld_q[BYTE_W-1:0]     <= wr_data;
            if (wr_addr == A_RLD_H) rld_q[CNT_W-1:BYTE_W] <= wr_data;
        end
    end

    // Mode state machine: next state
    always_comb begin
        unique case ({run_q, split_q})
            2'b10:   state_d = ST_WIDE;
            2'b11:   state_d = ST_SPLIT;
            default: state_d = ST_HALT;
        endcase
    end

    // Mode state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    drt_tick_gen #(
        .SYS_DIV    (SYS_DIV),
        .EXT_DIV    (EXT_DIV),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (src_q),
        .ext_osc(ext_osc),
        .tick   (tick_w)
    );

    drt_count_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state_q),
        .tick     (tick_w),
        .wr_lo    (wr_en && (wr_addr == A_CNT_L)),
        .wr_hi    (wr_en && (wr_addr == A_CNT_H)),
        .wr_data  (wr_data),
        .rld      (rld_q),
        .lo_en    (lo_en_q),
        .cnt      (count_o),
        .set_lo   (set_lo_w),
        .set_hi   (set_hi_w),
        .ovf_pulse(ovf_pulse)
    );

    // Sticky flags; a hardware set wins over a software write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_hi_q <= 1'b0;
            fl_lo_q <= 1'b0;
        end else begin
            fl_hi_q <= (wr_flags ? wr_data[1] : fl_hi_q) | set_hi_w;
            fl_lo_q <= (wr_flags ? wr_data[0] : fl_lo_q) | set_lo_w;
        end
    end

    // Outputs
    always_comb begin
        flag_hi = fl_hi_q;
        flag_lo = fl_lo_q;
        irq     = irq_en_q && (fl_hi_q || (lo_en_q && fl_lo_q));
    end
endmodule

// File: rtl/drt_checker.sv
module drt_checker
    import drt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input tmr_state_e       state,
    input logic             tick,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] rld,
    input logic             lo_en,
    input logic             flag_hi,
    input logic             flag_lo,
    input logic             irq,
    input logic             ovf_pulse
);
    p_hold_when_halted_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !wr_en) |=> $stable(count));

    p_wide_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WIDE && tick && !wr_en && count == 16'hFFFF) |=> (count == $past(rld)));

    p_pulse_with_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> flag_hi);

    p_lo_flag_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WIDE && !lo_en && !flag_lo && !wr_en) |=> !flag_lo);

    p_split_lo_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SPLIT && tick && !wr_en && count[BYTE_W-1:0] == 8'hFF)
        |=> (count[BYTE_W-1:0] == $past(rld[BYTE_W-1:0])));

    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_hi || flag_lo));
endmodule

bind dual_reload_timer drt_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .state    (state_q),
    .tick     (tick_w),
    .count    (count_o),
    .rld      (rld_q),
    .lo_en    (lo_en_q),
    .flag_hi  (flag_hi),
    .flag_lo  (flag_lo),
    .irq      (irq),
    .ovf_pulse(ovf_pulse)
);

// File: tb/dual_reload_timer_test.sv
`timescale 1ns/1ps
module dual_reload_timer_test;
    typedef struct {
        logic [15:0] v;
        logic        wrap;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        ext_osc = 1'b0;
    logic [15:0] count_o;
    logic        flag_hi, flag_lo, irq, ovf_pulse;

    int    n_checks = 0;
    int    n_err = 0;
    int    cyc = 0;
    bit    mon_on = 0;
    bit    ext_run = 0;
    string cur_req = "R4";
    exp_t  sb_q[$];
    logic [15:0] pv = '0;
    logic [15:0] rld_m = '0;
    logic [15:0] prev_cnt = '0;

    dual_reload_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ext_osc(ext_osc), .count_o(count_o),
        .flag_hi(flag_hi), .flag_lo(flag_lo), .irq(irq), .ovf_pulse(ovf_pulse)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            repeat (5) @(negedge clk);
            if (ext_run) ext_osc = ~ext_osc;
        end
    end

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic exp_t model_next(logic [15:0] c, bit split, logic [15:0] r);
        exp_t e;
        if (!split) begin
            e.wrap = (c == 16'hFFFF);
            e.v    = e.wrap ? r : c + 16'd1;
        end else begin
            e.wrap    = (c[15:8] == 8'hFF);
            e.v[7:0]  = (c[7:0] == 8'hFF) ? r[7:0] : c[7:0] + 8'd1;
            e.v[15:8] = e.wrap ? r[15:8] : c[15:8] + 8'd1;
        end
        return e;
    endfunction

    // Scoreboard monitor: every count change must match the next prediction
    always @(negedge clk) begin
        if (rst_n && mon_on && count_o !== prev_cnt) begin
            if (sb_q.size() == 0) begin
                check(1'b0, cur_req, "unpredicted count change", {16'h0, count_o}, {16'h0, prev_cnt});
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(count_o == e.v, cur_req, "count sequence", {16'h0, count_o}, {16'h0, e.v});
                check(ovf_pulse == e.wrap, "R5", "ovf_pulse at change", {31'h0, ovf_pulse}, {31'h0, e.wrap});
            end
            prev_cnt = count_o;
        end
    end

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 3'd3) rld_m[7:0]  = d;
        if (a == 3'd4) rld_m[15:8] = d;
    endtask

    task automatic wr_cnt_byte(bit hi, logic [7:0] d);
        logic [15:0] nv;
        nv = pv;
        if (hi) nv[15:8] = d; else nv[7:0] = d;
        if (nv != pv) begin
            exp_t e;
            e.v = nv; e.wrap = 1'b0;
            sb_q.push_back(e);
        end
        wr(hi ? 3'd2 : 3'd1, d);
        pv = nv;
    endtask

    task automatic predict(int n, bit split);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e = model_next(pv, split, rld_m);
            sb_q.push_back(e);
            pv = e.v;
        end
    endtask

    task automatic halt_and_settle(logic [7:0] ctrl_val);
        wr(3'd0, ctrl_val);
        repeat (4) @(negedge clk);
        sb_q.delete();
        pv = count_o;
    endtask

    task automatic wait_change(output int at);
        logic [15:0] s;
        s  = count_o;
        at = -1;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (count_o !== s) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    initial begin
        #(200000 * 4);
        check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
        summary();
        $finish;
    end

    initial begin
        logic [15:0] snap;
        int t0, t1, t2;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(count_o == 16'h0, "R1", "count after reset", {16'h0, count_o}, 0);
        check(!flag_hi && !flag_lo, "R1", "flags after reset", {30'h0, flag_hi, flag_lo}, 0);
        check(!irq && !ovf_pulse, "R1", "irq/pulse after reset", {30'h0, irq, ovf_pulse}, 0);
        prev_cnt = count_o;
        mon_on = 1;

        // R2 byte writes, R4 16-bit reload, R5 overflow flag and pulse
        cur_req = "R2";
        wr(3'd3, 8'h34);
        wr(3'd4, 8'h12);
        wr_cnt_byte(0, 8'hFD);
        wr_cnt_byte(1, 8'hFF);
        cur_req = "R4";
        predict(30, 0);
        wr(3'd0, 8'h05);
        repeat (20) @(negedge clk);
        halt_and_settle(8'h04);
        // R3 hold while halted
        snap = count_o;
        repeat (20) @(negedge clk);
        check(count_o == snap, "R3", "count held while halted", {16'h0, count_o}, {16'h0, snap});
        check(flag_hi == 1'b1, "R5", "flag_hi after 16-bit overflow", {31'h0, flag_hi}, 1);
        check(flag_lo == 1'b0, "R6", "flag_lo with low enable off", {31'h0, flag_lo}, 0);
        check(irq == 1'b1, "R9", "irq from flag_hi", {31'h0, irq}, 1);
        wr(3'd0, 8'h00);
        check(irq == 1'b0, "R9", "irq masked by enable", {31'h0, irq}, 0);
        check(flag_hi == 1'b1, "R8", "flag_hi sticky", {31'h0, flag_hi}, 1);
        wr(3'd5, 8'h00);
        check(!flag_hi && !flag_lo, "R8", "flags cleared by write", {30'h0, flag_hi, flag_lo}, 0);

        // R6 low-byte rollover flag in 16-bit mode
        cur_req = "R2";
        wr(3'd0, 8'h0C);
        wr_cnt_byte(0, 8'hFE);
        wr_cnt_byte(1, 8'h20);
        cur_req = "R4";
        predict(30, 0);
        wr(3'd0, 8'h0D);
        repeat (10) @(negedge clk);
        halt_and_settle(8'h0C);
        check(flag_lo == 1'b1, "R6", "flag_lo on low rollover", {31'h0, flag_lo}, 1);
        check(flag_hi == 1'b0, "R6", "no flag_hi without 16-bit overflow", {31'h0, flag_hi}, 0);
        check(irq == 1'b1, "R9", "irq from flag_lo", {31'h0, irq}, 1);
        wr(3'd0, 8'h04);
        check(irq == 1'b0, "R9", "irq ignores flag_lo without low enable", {31'h0, irq}, 0);
        wr(3'd5, 8'h02);
        check(flag_hi && !flag_lo, "R8", "flag write loads bits", {30'h0, flag_hi, flag_lo}, 32'h2);
        wr(3'd5, 8'h00);

        // R7 split mode
        wr(3'd0, 8'h00);
        wr(3'd3, 8'hF0);
        wr(3'd4, 8'h80);
        cur_req = "R2";
        wr_cnt_byte(0, 8'hFE);
        wr_cnt_byte(1, 8'hFE);
        cur_req = "R7";
        predict(40, 1);
        wr(3'd0, 8'h03);
        repeat (30) @(negedge clk);
        halt_and_settle(8'h00);
        check(flag_lo && flag_hi, "R7", "both split flags", {30'h0, flag_hi, flag_lo}, 32'h3);
        check(irq == 1'b0, "R9", "irq off with enable clear", {31'h0, irq}, 0);
        wr(3'd5, 8'h00);

        // R10 divide-by-12 source
        cur_req = "R2";
        wr_cnt_byte(0, 8'h00);
        wr_cnt_byte(1, 8'h00);
        cur_req = "R10";
        predict(10, 0);
        wr(3'd0, 8'h11);
        wait_change(t0);
        wait_change(t1);
        wait_change(t2);
        check(t1 - t0 == 12, "R10", "div12 interval", t1 - t0, 12);
        check(t2 - t1 == 12, "R10", "div12 interval", t2 - t1, 12);
        halt_and_settle(8'h00);

        // R10 external oscillator source
        ext_run = 1;
        predict(10, 0);
        wr(3'd0, 8'h21);
        wait_change(t0);
        wait_change(t1);
        wait_change(t2);
        check(t1 - t0 == 80, "R10", "ext/8 interval", t1 - t0, 80);
        check(t2 - t1 == 80, "R10", "ext/8 interval", t2 - t1, 80);
        halt_and_settle(8'h00);
        ext_run = 0;

        summary();
        $finish;
    end
endmodule